// File: doc/BRIEF.md
# DMA Channel Event and Status Register Block

This block is the shared register block of a multi-channel DMA engine. Each physical channel raises single-cycle pulses for four kinds of event: transfer done, source-side error, destination-side error and configuration error. The block latches every pulse into a sticky per-channel flag, one flag word for each event class. Bit n of every flag word belongs to channel n.

Software sees each flag word at two addresses. The reported view is read-only. The raw view has the same content but clears bits on a write-one. A status word mirrors the per-channel busy lines, so software can avoid starting a channel that is still running. Two plain read/write words carry the arbitration mode and the group priority out to the arbiter. A single interrupt line is high while any flag of any class is set.

Register access is a simple strobe interface. A write takes effect at the clock edge where `wr_en` is high. A read returns its data in `rdata` on the edge after `rd_en`, and `rdata` holds that value until the next read.

Top module: `dmaev_hub`

## Requirements
- R1: After a synchronous reset, every flag word, the status word, both priority words, `rdata` and `irq` are zero.
- R2: A pulse on bit n of an event input sets bit n of that class's flag word at the same clock edge. The bit stays set until it is cleared. The reported views are at 0x800 (done), 0x804 (source error), 0x808 (destination error) and 0x80C (configuration error). Classes are independent of one another.
- R3: The raw views are at 0x810, 0x814, 0x818 and 0x81C, in the same class order. Each reads the same flags as its reported view. Writing 1 to bit n clears channel n's flag in that class, and writing 0 leaves it unchanged.
- R4: When an event pulse and a clear write hit the same bit in the same cycle, the event wins and the bit ends set.
- R5: Writes to the reported views (0x800 to 0x80C) have no effect on any flag.
- R6: The status word at 0x820 reads 1 in bit n while channel n's busy input is high. The busy input is sampled through one register stage.
- R7: The word at 0x828 sets the arbitration mode and the word at 0x824 sets the group priority. Both are read/write, both drive their output ports, and both reset to zero, which means all channels have equal priority.
- R8: `irq` is high exactly when at least one bit of any flag word is set, and it changes at the same edge as the flags.
- R9: Bits at and above NCH in the flag and status words read as zero. Unmapped addresses read as zero.
- R10: `rdata` is updated only on the edge after a read strobe and holds its value otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| addr | input | AW | Byte address of the register |
| wdata | input | DW | Write data |
| rdata | output | DW | Read data, registered |
| evt_done | input | NCH | Transfer-done pulses, one per channel |
| evt_src_err | input | NCH | Source-error pulses |
| evt_dst_err | input | NCH | Destination-error pulses |
| evt_cfg_err | input | NCH | Configuration-error pulses |
| busy_in | input | NCH | Per-channel busy levels |
| irq | output | 1 | Combined interrupt, registered |
| arb_cfg | output | DW | Arbitration mode word |
| grp_prio | output | DW | Group priority word |

## Verification
A table of steps drives each class with event pulses and clear masks. The patterns include:
- single bits at the lowest and highest channel, which locate bit n at channel n;
- multi-bit masks in one class while the other classes are watched, which separates the classes;
- clear masks that overlap a simultaneous event, which expose whether the event or the clear takes priority;
- all-ones clear masks, which show that bits above the channel count neither stick nor read back.

Directed steps follow the table. Writes to the reported views show that those views are read-only. A busy pattern is changed and read back through the sampling stage. Reads between state changes show whether `rdata` holds. A full clear followed by a single event toggles the interrupt off and then on.

// File: rtl/dmaev_pkg.sv
package dmaev_pkg;
  localparam int NCLS     = 4;
  localparam int REP_BASE = 'h800;
  localparam int RAW_BASE = 'h810;
  localparam int STAT_OFS = 'h820;
  localparam int GRP_OFS  = 'h824;
  localparam int ARB_OFS  = 'h828;
  localparam int WSTEP    = 4;

  typedef enum logic [1:0] {
    CLS_DONE   = 2'd0,
    CLS_SRCERR = 2'd1,
    CLS_DSTERR = 2'd2,
    CLS_CFGERR = 2'd3
  } evt_cls_e;
endpackage

// File: rtl/dmaev_flags.sv
module dmaev_flags #(
  parameter int NCH = 8
) (
  input  logic           clk,
  input  logic           rst,
  input  logic [NCH-1:0] evt,
  input  logic           clr_we,
  input  logic [NCH-1:0] clr_mask,
  output logic [NCH-1:0] flags,
  output logic [NCH-1:0] flags_nxt
);
  logic [NCH-1:0] clr_eff;

  always_comb begin
    clr_eff   = clr_we ? clr_mask : '0;
    // a pulse in the same cycle as a clear keeps the bit set
    flags_nxt = (flags & ~clr_eff) | evt;
  end

  always_ff @(posedge clk) begin
    if (rst) flags <= '0;
    else     flags <= flags_nxt;
  end
endmodule

// File: rtl/dmaev_cfg.sv
module dmaev_cfg #(
  parameter int AW = 12,
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr_en,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] arb_q,
  output logic [DW-1:0] grp_q
);
  import dmaev_pkg::*;
  localparam logic [AW-1:0] A_ARB = AW'(ARB_OFS);
  localparam logic [AW-1:0] A_GRP = AW'(GRP_OFS);

  always_ff @(posedge clk) begin
    if (rst) begin
      arb_q <= '0;
      grp_q <= '0;
    end else if (wr_en) begin
      if (addr == A_ARB) arb_q <= wdata;
      if (addr == A_GRP) grp_q <= wdata;
    end
  end
endmodule

// File: rtl/dmaev_rdmux.sv
module dmaev_rdmux #(
  parameter int NCH = 8,
  parameter int AW  = 12,
  parameter int DW  = 32
) (
  input  logic                                  clk,
  input  logic                                  rst,
  input  logic                                  rd_en,
  input  logic [AW-1:0]                         addr,
  input  logic [dmaev_pkg::NCLS-1:0][NCH-1:0]   flg,
  input  logic [NCH-1:0]                        busy_q,
  input  logic [DW-1:0]                         arb_q,
  input  logic [DW-1:0]                         grp_q,
  output logic [DW-1:0]                         rdata
);
  import dmaev_pkg::*;
  localparam logic [AW-1:0] A_STAT = AW'(STAT_OFS);
  localparam logic [AW-1:0] A_ARB  = AW'(ARB_OFS);
  localparam logic [AW-1:0] A_GRP  = AW'(GRP_OFS);

  logic [DW-1:0] rd_nxt;

  always_comb begin
    rd_nxt = '0;
    for (int k = 0; k < NCLS; k++) begin
      if (addr == AW'(REP_BASE + WSTEP*k) || addr == AW'(RAW_BASE + WSTEP*k))
        rd_nxt[NCH-1:0] = flg[k];
    end
    if (addr == A_STAT) rd_nxt[NCH-1:0] = busy_q;
    if (addr == A_ARB)  rd_nxt = arb_q;
    if (addr == A_GRP)  rd_nxt = grp_q;
  end

  always_ff @(posedge clk) begin
    if (rst)        rdata <= '0;
    else if (rd_en) rdata <= rd_nxt;
  end
endmodule

// File: rtl/dmaev_hub.sv
module dmaev_hub #(
  parameter int NCH = 8,
  parameter int AW  = 12,
  parameter int DW  = 32
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           wr_en,
  input  logic           rd_en,
  input  logic [AW-1:0]  addr,
  input  logic [DW-1:0]  wdata,
  output logic [DW-1:0]  rdata,
  input  logic [NCH-1:0] evt_done,
  input  logic [NCH-1:0] evt_src_err,
  input  logic [NCH-1:0] evt_dst_err,
  input  logic [NCH-1:0] evt_cfg_err,
  input  logic [NCH-1:0] busy_in,
  output logic           irq,
  output logic [DW-1:0]  arb_cfg,
  output logic [DW-1:0]  grp_prio
);
  import dmaev_pkg::*;

  logic [NCLS-1:0][NCH-1:0] evt_all;
  logic [NCLS-1:0][NCH-1:0] flg;
  logic [NCLS-1:0][NCH-1:0] flg_nxt;
  logic [NCLS-1:0]          clr_we;
  logic [NCH-1:0]           busy_q;

  assign evt_all[CLS_DONE]   = evt_done;
  assign evt_all[CLS_SRCERR] = evt_src_err;
  assign evt_all[CLS_DSTERR] = evt_dst_err;
  assign evt_all[CLS_CFGERR] = evt_cfg_err;

  for (genvar k = 0; k < NCLS; k++) begin : g_cls
    assign clr_we[k] = wr_en && (addr == AW'(RAW_BASE + WSTEP*k));
    dmaev_flags #(.NCH(NCH)) u_flags (
      .clk       (clk),
      .rst       (rst),
      .evt       (evt_all[k]),
      .clr_we    (clr_we[k]),
      .clr_mask  (wdata[NCH-1:0]),
      .flags     (flg[k]),
      .flags_nxt (flg_nxt[k])
    );
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      busy_q <= '0;
      irq    <= 1'b0;
    end else begin
      busy_q <= busy_in;
      irq    <= |flg_nxt;
    end
  end

  dmaev_cfg #(.AW(AW), .DW(DW)) u_cfg (
    .clk   (clk),
    .rst   (rst),
    .wr_en (wr_en),
    .addr  (addr),
    .wdata (wdata),
    .arb_q (arb_cfg),
    .grp_q (grp_prio)
  );

  dmaev_rdmux #(.NCH(NCH), .AW(AW), .DW(DW)) u_rd (
    .clk    (clk),
    .rst    (rst),
    .rd_en  (rd_en),
    .addr   (addr),
    .flg    (flg),
    .busy_q (busy_q),
    .arb_q  (arb_cfg),
    .grp_q  (grp_prio),
    .rdata  (rdata)
  );
endmodule

// File: rtl/dmaev_hub_chk.sv
module dmaev_hub_chk #(
  parameter int NCH = 8,
  parameter int AW  = 12,
  parameter int DW  = 32
) (
  input logic                                clk,
  input logic                                rst,
  input logic                                wr_en,
  input logic                                rd_en,
  input logic [AW-1:0]                       addr,
  input logic [DW-1:0]                       wdata,
  input logic [DW-1:0]                       rdata,
  input logic [dmaev_pkg::NCLS-1:0][NCH-1:0] evt,
  input logic [dmaev_pkg::NCLS-1:0][NCH-1:0] flg,
  input logic [NCH-1:0]                      busy_q,
  input logic                                irq
);
  import dmaev_pkg::*;

  // R1
  rst_clean_chk: assert property (@(posedge clk)
    rst |=> (!irq && flg == '0 && rdata == '0));

  // R8
  irq_match_chk: assert property (@(posedge clk) disable iff (rst)
    irq == (|flg));

  // R6
  stat_read_chk: assert property (@(posedge clk) disable iff (rst)
    (rd_en && addr == AW'(STAT_OFS)) |=> (rdata[NCH-1:0] == $past(busy_q)));

  // R10
  rdata_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !rd_en |=> $stable(rdata));

  for (genvar k = 0; k < NCLS; k++) begin : g_chk
    // R2
    evt_set_chk: assert property (@(posedge clk) disable iff (rst)
      (|evt[k]) |=> ((flg[k] & $past(evt[k])) == $past(evt[k])));

    // R3
    raw_clr_chk: assert property (@(posedge clk) disable iff (rst)
      (wr_en && addr == AW'(RAW_BASE + WSTEP*k) && evt[k] == '0)
      |=> ((flg[k] & $past(wdata[NCH-1:0])) == '0));

    // R5
    rep_ro_chk: assert property (@(posedge clk) disable iff (rst)
      (wr_en && addr == AW'(REP_BASE + WSTEP*k) && evt[k] == '0)
      |=> $stable(flg[k]));
  end
endmodule

bind dmaev_hub dmaev_hub_chk #(.NCH(NCH), .AW(AW), .DW(DW)) u_chk (
  .clk    (clk),
  .rst    (rst),
  .wr_en  (wr_en),
  .rd_en  (rd_en),
  .addr   (addr),
  .wdata  (wdata),
  .rdata  (rdata),
  .evt    (evt_all),
  .flg    (flg),
  .busy_q (busy_q),
  .irq    (irq)
);

// File: tb/sim_dmaev_hub.sv
`timescale 1ns/1ps
module sim_dmaev_hub;
  localparam int NCH = 8;
  localparam int AW  = 12;
  localparam int DW  = 32;
  localparam int NV  = 10;

  // {class, event mask, clear mask, expected flags of that class}
  localparam logic [73:0] VEC [NV] = '{
    {2'd0, 8'h01, 32'h0000_0000, 32'h0000_0001},
    {2'd0, 8'h80, 32'h0000_0000, 32'h0000_0081},
    {2'd1, 8'h0F, 32'h0000_0000, 32'h0000_000F},
    {2'd0, 8'h00, 32'h0000_0001, 32'h0000_0080},
    {2'd1, 8'h02, 32'h0000_0003, 32'h0000_000E},
    {2'd2, 8'h3C, 32'h0000_0000, 32'h0000_003C},
    {2'd3, 8'h55, 32'hFFFF_FFFF, 32'h0000_0055},
    {2'd2, 8'h00, 32'hFFFF_FFFF, 32'h0000_0000},
    {2'd3, 8'hAA, 32'h0000_0000, 32'h0000_00FF},
    {2'd0, 8'h00, 32'hFFFF_FF00, 32'h0000_0080}
  };

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          wr_en = 1'b0, rd_en = 1'b0;
  logic [AW-1:0] addr = '0;
  logic [DW-1:0] wdata = '0;
  logic [DW-1:0] rdata;
  logic [NCH-1:0] evt_done = '0, evt_src_err = '0, evt_dst_err = '0, evt_cfg_err = '0;
  logic [NCH-1:0] busy_in = '0;
  logic          irq;
  logic [DW-1:0] arb_cfg, grp_prio;

  int  n_chk = 0;
  int  n_err = 0;
  bit  done  = 0;

  always #10 clk = ~clk;

  dmaev_hub #(.NCH(NCH), .AW(AW), .DW(DW)) u0 (
    .clk(clk), .rst(rst), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
    .wdata(wdata), .rdata(rdata), .evt_done(evt_done),
    .evt_src_err(evt_src_err), .evt_dst_err(evt_dst_err),
    .evt_cfg_err(evt_cfg_err), .busy_in(busy_in), .irq(irq),
    .arb_cfg(arb_cfg), .grp_prio(grp_prio)
  );

  task automatic chk(input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic reg_wr(input logic [AW-1:0] a, input logic [DW-1:0] d);
    @(negedge clk);
    wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic reg_rd(input logic [AW-1:0] a, output logic [DW-1:0] d);
    @(negedge clk);
    rd_en = 1'b1; addr = a;
    @(negedge clk);
    rd_en = 1'b0;
    d = rdata;
  endtask

  task automatic step(input logic [1:0] cls, input logic [7:0] ev, input logic [31:0] clr);
    @(negedge clk);
    case (cls)
      2'd0: evt_done    = ev;
      2'd1: evt_src_err = ev;
      2'd2: evt_dst_err = ev;
      default: evt_cfg_err = ev;
    endcase
    if (clr != 0) begin
      wr_en = 1'b1; addr = AW'(12'h810 + 4*cls); wdata = clr;
    end
    @(negedge clk);
    evt_done = '0; evt_src_err = '0; evt_dst_err = '0; evt_cfg_err = '0;
    wr_en = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_err++; n_chk++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("  Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end

  initial begin
    logic [DW-1:0] d;
    logic [DW-1:0] held;
    logic [DW-1:0] irq_w;
    repeat (3) @(negedge clk);
    rst = 1'b0;

    // R1 reset state
    chk("R1 irq", {31'd0, irq}, 32'd0);
    for (int k = 0; k < 4; k++) begin
      reg_rd(AW'(12'h800 + 4*k), d); chk("R1 reported", d, 32'd0);
      reg_rd(AW'(12'h810 + 4*k), d); chk("R1 raw", d, 32'd0);
    end
    reg_rd(12'h820, d); chk("R1 status", d, 32'd0);
    reg_rd(12'h828, d); chk("R7 arb reset", d, 32'd0);
    reg_rd(12'h824, d); chk("R7 grp reset", d, 32'd0);

    // table: R2 set, R3 clear, R4 event wins, R8 irq
    for (int i = 0; i < NV; i++) begin
      step(VEC[i][73:72], VEC[i][71:64], VEC[i][63:32]);
      reg_rd(AW'(12'h810 + 4*VEC[i][73:72]), d);
      chk("R3 raw view", d, VEC[i][31:0]);
      reg_rd(AW'(12'h800 + 4*VEC[i][73:72]), d);
      chk("R2 reported view", d, VEC[i][31:0]);
      chk("R8 irq on", {31'd0, irq}, 32'd1);
    end
    // R2 classes independent: final state of each class
    reg_rd(12'h804, d); chk("R2 class1", d, 32'h0E);
    reg_rd(12'h808, d); chk("R2 class2", d, 32'h00);

    // R5 writes to reported views ignored
    reg_wr(12'h800, 32'hFFFF_FFFF);
    reg_rd(12'h810, d); chk("R5 write ones", d, 32'h80);
    reg_wr(12'h804, 32'h0);
    reg_rd(12'h814, d); chk("R5 write zero", d, 32'h0E);

    // R9 upper bits and unmapped addresses
    reg_wr(12'h81C, 32'hFFFF_FF00);
    reg_rd(12'h81C, d); chk("R9 upper bits zero", d, 32'hFF);
    reg_rd(12'h830, d); chk("R9 unmapped", d, 32'h0);
    reg_rd(12'h080, d); chk("R9 low unmapped", d, 32'h0);

    // R10 rdata holds without a read strobe
    reg_rd(12'h814, held);
    step(2'd1, 8'h01, 32'h0);
    repeat (2) @(negedge clk);
    chk("R10 hold", rdata, held);
    reg_rd(12'h814, d); chk("R10 new read", d, 32'h0F);

    // R6 busy status
    @(negedge clk); busy_in = 8'hA5;
    repeat (2) @(negedge clk);
    reg_rd(12'h820, d); chk("R6 status A5", d, 32'hA5);
    @(negedge clk); busy_in = 8'h3C;
    repeat (2) @(negedge clk);
    reg_rd(12'h820, d); chk("R6 status 3C", d, 32'h3C);

    // R7 priority words
    reg_wr(12'h828, 32'h3);
    reg_wr(12'h824, 32'h1234_5678);
    chk("R7 arb out", arb_cfg, 32'h3);
    chk("R7 grp out", grp_prio, 32'h1234_5678);
    reg_rd(12'h828, d); chk("R7 arb read", d, 32'h3);
    reg_rd(12'h824, d); chk("R7 grp read", d, 32'h1234_5678);

    // R8 irq follows flags
    for (int k = 0; k < 4; k++) reg_wr(AW'(12'h810 + 4*k), 32'hFFFF_FFFF);
    irq_w = {31'd0, irq}; chk("R8 irq off", irq_w, 32'd0);
    step(2'd2, 8'h10, 32'h0);
    irq_w = {31'd0, irq}; chk("R8 irq single", irq_w, 32'd1);
    reg_rd(12'h808, d); chk("R2 class2 bit4", d, 32'h10);
    reg_wr(12'h818, 32'h10);
    irq_w = {31'd0, irq}; chk("R8 irq cleared", irq_w, 32'd0);

    done = 1;
    $display("  Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule